// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for the memory addressing modes of a 16/32-bit processor and then carries out the operand fetch on a 16-bit bus. It takes the addressing mode, the register number, the operand size, the whole register file, the two words at the head of the prefetch queue and the address of the current instruction. A one-cycle `start` pulse begins the work. The block then issues its microcycles in a fixed order, one per clock: internal idle cycles, prefetch slots and data reads. When they are finished it raises `done` for one cycle. In that cycle it presents the assembled operand, the effective address and any write-back to an address register.

The indexed modes decode a brief extension word. That word names a data or address register as the index, takes either its full 32 bits or its sign-extended low half, and adds a signed 8-bit displacement. Register-direct modes return the register contents and issue no microcycles. Immediate modes return data taken from the prefetch queue and issue only prefetch slots. Arithmetic on the operand is outside this block.

Top module: `ea_unit`

## Requirements
- R1: Effective address per mode (mode code in brackets): indirect [2] and post-increment [3] use An. Pre-decrement [4] uses An minus the step. Displacement [5] uses An plus `ext0` sign-extended. PC displacement [7] uses `instr_addr`+2 plus `ext0` sign-extended. Absolute short [9] uses `ext0` sign-extended. Absolute long [10] uses {`ext0`,`ext1`}. The address is presented on `ea` while `done` is high.
- R2: Indexed [6] and PC-indexed [8] modes add an index term to the base. The base is An for [6] and `instr_addr`+2 for [8]. `ext0[15:12]` selects the index register: 0-7 are D0-D7 and 8-15 are A0-A7. `ext0[11]`=1 takes the full 32 bits of that register; 0 takes its low 16 bits sign-extended. `ext0[7:0]` is a signed displacement that is also added.
- R3: Post-increment and pre-decrement raise `wb_en` together with `done` and give `wb_reg`=register number and `wb_val`=the updated An. The step is 4 for long, 2 for word and 1 for byte, except that a byte step on A7 is 2. No other mode raises `wb_en`.
- R4: The `cyc` encoding is 0 none, 1 idle, 2 prefetch, 3 read. Indexed modes issue idle, prefetch, reads. Displacement modes and absolute short issue prefetch, reads. Absolute long issues prefetch, prefetch, reads. Pre-decrement issues idle, reads. Indirect and post-increment issue reads only. Immediate issues one prefetch (two for long).
- R5: A long operand takes two reads: the first at the effective address, supplying bits 31:16, and the second at the effective address+2, supplying bits 15:0. Byte and word operands take one read at the effective address.
- R6: A word operand is `bus_din` zero-extended. A byte operand is `bus_din[7:0]` zero-extended. Immediate data is `ext0[7:0]`, `ext0` or {`ext0`,`ext1`} by size. Register direct [0] and address register direct [1] return the full register and issue no microcycles.
- R7: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a single-cycle pulse in the cycle after the last microcycle, or in the cycle after `start` when there are none.
- R8: `start` is ignored while `busy` is high. The current operation's timing, address and operand are not affected.
- R9: During and after reset, `busy`, `done` and `wb_en` are 0 and `cyc` is 0. A reset in mid-operation abandons it.
- R10: All address arithmetic, including the +2 of the second read, wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| mode | input | 4 | Addressing mode code |
| reg_num | input | 3 | Register number of the mode |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| regs | input | 512 | Register file, D0-D7 then A0-A7, 32 bits each, D0 in the low bits |
| ext0 | input | 16 | Extension word at the head of the prefetch queue |
| ext1 | input | 16 | Following prefetch queue word |
| instr_addr | input | 32 | Address of the current instruction |
| cyc | output | 2 | Microcycle in progress: 0 none, 1 idle, 2 prefetch, 3 read |
| busy | output | 1 | Operation in progress |
| bus_addr | output | 32 | Read address, valid when `cyc`=3 |
| bus_din | input | 16 | Read data, sampled at the clock edge that ends a read |
| done | output | 1 | Operation complete; outputs valid |
| ea | output | 32 | Effective address |
| operand | output | 32 | Fetched operand |
| wb_en | output | 1 | Address register update valid |
| wb_reg | output | 3 | Address register number to update |
| wb_val | output | 32 | New address register value |

## Verification
The checker takes for granted that `mode` carries one of the twelve defined codes and `size` is never 3. It also takes for granted that `regs`, `ext0`, `ext1` and `instr_addr` hold steady from `start` until `done`, and that `bus_din` answers the address presented in the same read cycle. The bench meets these conditions by holding every operand input constant across each operation. It drives `bus_din` combinationally from a fixed function of `bus_addr`, and it uses only listed mode and size codes. The only deliberate break of the handshake is a `start` raised while busy, which exercises the rule that such a request is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_DREG    = 4'd0,
    AM_AREG    = 4'd1,
    AM_IND     = 4'd2,
    AM_POSTI   = 4'd3,
    AM_PRED    = 4'd4,
    AM_DISP    = 4'd5,
    AM_INDEX   = 4'd6,
    AM_PCDISP  = 4'd7,
    AM_PCINDEX = 4'd8,
    AM_ABSS    = 4'd9,
    AM_ABSL    = 4'd10,
    AM_IMM     = 4'd11
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } osize_e;

  typedef enum logic [1:0] {
    MC_NONE = 2'd0,
    MC_IDLE = 2'd1,
    MC_PREF = 2'd2,
    MC_READ = 2'd3
  } mcyc_e;

  // microcycle plan of one operation
  typedef struct packed {
    logic       idle;
    logic [1:0] n_pref;
    logic [1:0] n_read;
  } plan_t;

endpackage

// File: rtl/ea_index.sv
// Brief extension word decode: index register (word or long) plus 8-bit displacement.
module ea_index #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic [DW-1:0]          ext,
  input  logic [2*NREG*2*DW-1:0] regs,
  output logic [2*DW-1:0]        idx_term
);
  localparam int AW       = 2 * DW;
  localparam int SW       = $clog2(2 * NREG);
  localparam int LONG_BIT = DW - SW - 1;

  logic [SW-1:0] sel;
  logic [AW-1:0] xreg;
  logic [AW-1:0] xval;
  logic [AW-1:0] disp;
  logic          unused_ext_bits;

  assign sel  = ext[DW-1 -: SW];
  assign xreg = regs[int'(sel)*AW +: AW];
  assign xval = ext[LONG_BIT] ? xreg : {{(AW-DW){xreg[DW-1]}}, xreg[DW-1:0]};
  assign disp = {{(AW-8){ext[7]}}, ext[7:0]};
  assign idx_term = xval + disp;
  assign unused_ext_bits = ^ext[LONG_BIT-1:8];
endmodule

// File: rtl/ea_addr.sv
// Address formation, register write-back and microcycle plan per mode.
module ea_addr import ea_pkg::*; #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  amode_e                 mode,
  input  logic [$clog2(NREG)-1:0] rnum,
  input  osize_e                 size,
  input  logic [2*NREG*2*DW-1:0] regs,
  input  logic [DW-1:0]          ext0,
  input  logic [DW-1:0]          ext1,
  input  logic [2*DW-1:0]        ia,
  input  logic [2*DW-1:0]        idx_term,
  output logic [2*DW-1:0]        ea,
  output logic                   wb,
  output logic [2*DW-1:0]        wb_val,
  output logic [2*DW-1:0]        init_val,
  output plan_t                  plan
);
  localparam int AW = 2 * DW;
  localparam int RW = $clog2(NREG);

  logic [AW-1:0] an, dn, sx0, pc_base, step;
  logic [1:0]    reads;

  assign an      = regs[(NREG + int'(rnum))*AW +: AW];
  assign dn      = regs[int'(rnum)*AW +: AW];
  assign sx0     = {{(AW-DW){ext0[DW-1]}}, ext0};
  assign pc_base = ia + AW'(2);
  assign reads   = (size == SZ_LONG) ? 2'd2 : 2'd1;

  always_comb begin
    unique case (size)
      SZ_LONG: step = AW'(4);
      SZ_WORD: step = AW'(2);
      default: step = (rnum == RW'(NREG-1)) ? AW'(2) : AW'(1);
    endcase
  end

  always_comb begin
    ea       = '0;
    wb       = 1'b0;
    wb_val   = '0;
    init_val = '0;
    plan     = '0;
    unique case (mode)
      AM_AREG: init_val = an;
      AM_IND: begin
        ea = an;
        plan.n_read = reads;
      end
      AM_POSTI: begin
        ea = an;
        wb = 1'b1;
        wb_val = an + step;
        plan.n_read = reads;
      end
      AM_PRED: begin
        ea = an - step;
        wb = 1'b1;
        wb_val = an - step;
        plan.idle = 1'b1;
        plan.n_read = reads;
      end
      AM_DISP: begin
        ea = an + sx0;
        plan.n_pref = 2'd1;
        plan.n_read = reads;
      end
      AM_INDEX: begin
        ea = an + idx_term;
        plan = '{idle: 1'b1, n_pref: 2'd1, n_read: reads};
      end
      AM_PCDISP: begin
        ea = pc_base + sx0;
        plan.n_pref = 2'd1;
        plan.n_read = reads;
      end
      AM_PCINDEX: begin
        ea = pc_base + idx_term;
        plan = '{idle: 1'b1, n_pref: 2'd1, n_read: reads};
      end
      AM_ABSS: begin
        ea = sx0;
        plan.n_pref = 2'd1;
        plan.n_read = reads;
      end
      AM_ABSL: begin
        ea = {ext0, ext1};
        plan.n_pref = 2'd2;
        plan.n_read = reads;
      end
      AM_IMM: begin
        plan.n_pref = reads;
        unique case (size)
          SZ_LONG: init_val = {ext0, ext1};
          SZ_WORD: init_val = {{(AW-DW){1'b0}}, ext0};
          default: init_val = {{(AW-8){1'b0}}, ext0[7:0]};
        endcase
      end
      default: init_val = dn;
    endcase
  end
endmodule

// File: rtl/ea_seq.sv
// Microcycle sequencer: idle, prefetch slots, reads, then a done cycle.
module ea_seq import ea_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  plan_t plan,
  output logic  accept,
  output mcyc_e cyc,
  output logic  busy,
  output logic  done,
  output logic  rd_idx
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_N, SQ_PREF, SQ_READ, SQ_FIN} sq_e;

  sq_e        st_q, st_n;
  logic [1:0] pref_q, pref_n, read_q, read_n;
  logic       idx_q, idx_n;

  function automatic sq_e route(input logic [1:0] p, input logic [1:0] r);
    if (p != 2'd0)      return SQ_PREF;
    else if (r != 2'd0) return SQ_READ;
    else                return SQ_FIN;
  endfunction

  assign accept = start && (st_q == SQ_IDLE);
  assign busy   = (st_q != SQ_IDLE);
  assign done   = (st_q == SQ_FIN);
  assign rd_idx = idx_q;

  always_comb begin
    unique case (st_q)
      SQ_N:    cyc = MC_IDLE;
      SQ_PREF: cyc = MC_PREF;
      SQ_READ: cyc = MC_READ;
      default: cyc = MC_NONE;
    endcase
  end

  always_comb begin
    st_n   = st_q;
    pref_n = pref_q;
    read_n = read_q;
    idx_n  = idx_q;
    unique case (st_q)
      SQ_IDLE: if (accept) begin
        pref_n = plan.n_pref;
        read_n = plan.n_read;
        idx_n  = 1'b0;
        st_n   = plan.idle ? SQ_N : route(plan.n_pref, plan.n_read);
      end
      SQ_N: st_n = route(pref_q, read_q);
      SQ_PREF: begin
        pref_n = pref_q - 2'd1;
        st_n   = route(pref_n, read_q);
      end
      SQ_READ: begin
        read_n = read_q - 2'd1;
        idx_n  = 1'b1;
        st_n   = (read_n != 2'd0) ? SQ_READ : SQ_FIN;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pref_q <= 2'd0;
      read_q <= 2'd0;
      idx_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pref_q <= pref_n;
      read_q <= read_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit import ea_pkg::*; #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [3:0]                    mode,
  input  logic [$clog2(NREG)-1:0]       reg_num,
  input  logic [1:0]                    size,
  input  logic [2*NREG*2*DW-1:0]        regs,
  input  logic [DW-1:0]                 ext0,
  input  logic [DW-1:0]                 ext1,
  input  logic [2*DW-1:0]               instr_addr,
  output logic [1:0]                    cyc,
  output logic                          busy,
  output logic [2*DW-1:0]               bus_addr,
  input  logic [DW-1:0]                 bus_din,
  output logic                          done,
  output logic [2*DW-1:0]               ea,
  output logic [2*DW-1:0]               operand,
  output logic                          wb_en,
  output logic [$clog2(NREG)-1:0]       wb_reg,
  output logic [2*DW-1:0]               wb_val
);
  localparam int AW = 2 * DW;
  localparam int RW = $clog2(NREG);

  logic [AW-1:0] idx_term, ea_c, wbv_c, init_c;
  logic          wb_c, accept, rd_idx;
  plan_t         plan_c;
  mcyc_e         cyc_e;

  logic [AW-1:0] ea_q, ea_n, wbv_q, wbv_n, op_q, op_n;
  logic          wb_q, wb_n;
  logic [RW-1:0] wbr_q, wbr_n;
  osize_e        sz_q, sz_n;

  ea_index #(.DW(DW), .NREG(NREG)) u_idx (
    .ext(ext0), .regs(regs), .idx_term(idx_term)
  );

  ea_addr #(.DW(DW), .NREG(NREG)) u_addr (
    .mode(amode_e'(mode)), .rnum(reg_num), .size(osize_e'(size)), .regs(regs),
    .ext0(ext0), .ext1(ext1), .ia(instr_addr), .idx_term(idx_term),
    .ea(ea_c), .wb(wb_c), .wb_val(wbv_c), .init_val(init_c), .plan(plan_c)
  );

  ea_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .plan(plan_c), .accept(accept),
    .cyc(cyc_e), .busy(busy), .done(done), .rd_idx(rd_idx)
  );

  always_comb begin
    ea_n  = ea_q;
    wb_n  = wb_q;
    wbv_n = wbv_q;
    wbr_n = wbr_q;
    sz_n  = sz_q;
    op_n  = op_q;
    if (accept) begin
      ea_n  = ea_c;
      wb_n  = wb_c;
      wbv_n = wbv_c;
      wbr_n = reg_num;
      sz_n  = osize_e'(size);
      op_n  = init_c;
    end else if (cyc_e == MC_READ) begin
      unique case (sz_q)
        SZ_LONG: if (rd_idx) op_n[DW-1:0] = bus_din;
                 else        op_n[AW-1:DW] = bus_din;
        SZ_WORD: op_n = {{(AW-DW){1'b0}}, bus_din};
        default: op_n = {{(AW-8){1'b0}}, bus_din[7:0]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      wb_q  <= 1'b0;
      wbv_q <= '0;
      wbr_q <= '0;
      sz_q  <= SZ_BYTE;
      op_q  <= '0;
    end else begin
      ea_q  <= ea_n;
      wb_q  <= wb_n;
      wbv_q <= wbv_n;
      wbr_q <= wbr_n;
      sz_q  <= sz_n;
      op_q  <= op_n;
    end
  end

  assign cyc      = cyc_e;
  assign bus_addr = ea_q + {{(AW-2){1'b0}}, rd_idx, 1'b0};
  assign ea       = ea_q;
  assign operand  = op_q;
  assign wb_en    = done && wb_q;
  assign wb_reg   = wbr_q;
  assign wb_val   = wbv_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cyc,
  input logic        busy,
  input logic        done,
  input logic [31:0] bus_addr,
  input logic        wb_en
);
  // R4: microcycles only while an operation is in flight
  p_cyc_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |-> busy);

  // R4: at most one idle microcycle, never followed by another
  p_one_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd1) |=> (cyc != 2'd1));

  // R5 R10: the second read of a pair is at the first address plus 2
  p_second_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(cyc) == 2'd3) |-> (bus_addr == $past(bus_addr) + 32'd2));

  // R7: done is a single pulse and ends the busy period
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7: done only inside a busy period
  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R3: write-back only together with done
  p_wb_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R8: a busy period runs until done whatever start does
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(cyc), .busy(busy), .done(done),
  .bus_addr(bus_addr), .wb_en(wb_en)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   mode = '0;
  logic [2:0]   reg_num = '0;
  logic [1:0]   size = '0;
  logic [511:0] regs;
  logic [15:0]  ext0 = '0, ext1 = '0;
  logic [31:0]  instr_addr = 32'h0000_1000;
  logic [1:0]   cyc;
  logic         busy, done, wb_en;
  logic [31:0]  bus_addr, ea, operand, wb_val;
  logic [15:0]  bus_din;
  logic [2:0]   wb_reg;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ea_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
    .size(size), .regs(regs), .ext0(ext0), .ext1(ext1), .instr_addr(instr_addr),
    .cyc(cyc), .busy(busy), .bus_addr(bus_addr), .bus_din(bus_din), .done(done),
    .ea(ea), .operand(operand), .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val)
  );

  function automatic logic [15:0] mem(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction
  assign bus_din = mem(bus_addr);

  function automatic logic [31:0] reg_init(input int i);
    case (i)
      0:  return 32'h0000_0010;
      1:  return 32'hFFFF_8002;
      2:  return 32'h0001_0100;
      8:  return 32'h0000_2000;
      9:  return 32'h0000_3000;
      10: return 32'hFFFF_FFFE;
      11: return 32'h0000_4000;
      15: return 32'h0000_8000;
      default: return 32'(i) * 32'h111;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  mode;
    logic [2:0]  rnum;
    logic [1:0]  size;
    logic [15:0] ext0;
    logic [15:0] ext1;
    logic [31:0] ea;
    logic        chk_ea;
    logic        wb;
    logic [31:0] wbv;
    logic [11:0] pat;
    logic [2:0]  plen;
    logic        fixed;
    logic [31:0] opv;
  } vec_t;

  localparam int NV = 24;
  // microcycle codes packed two bits each, first in the low bits: 1 idle, 2 prefetch, 3 read
  localparam vec_t VEC [NV] = '{
    '{4'd2, 3'd0, 2'd1, 16'h0000, 16'h0, 32'h0000_2000, 1'b1, 1'b0, 32'h0,          12'h003, 3'd1, 1'b0, 32'h0},
    '{4'd2, 3'd0, 2'd2, 16'h0000, 16'h0, 32'h0000_2000, 1'b1, 1'b0, 32'h0,          12'h00F, 3'd2, 1'b0, 32'h0},
    '{4'd3, 3'd1, 2'd0, 16'h0000, 16'h0, 32'h0000_3000, 1'b1, 1'b1, 32'h0000_3001,  12'h003, 3'd1, 1'b0, 32'h0},
    '{4'd3, 3'd7, 2'd0, 16'h0000, 16'h0, 32'h0000_8000, 1'b1, 1'b1, 32'h0000_8002,  12'h003, 3'd1, 1'b0, 32'h0},
    '{4'd3, 3'd1, 2'd2, 16'h0000, 16'h0, 32'h0000_3000, 1'b1, 1'b1, 32'h0000_3004,  12'h00F, 3'd2, 1'b0, 32'h0},
    '{4'd4, 3'd1, 2'd1, 16'h0000, 16'h0, 32'h0000_2FFE, 1'b1, 1'b1, 32'h0000_2FFE,  12'h00D, 3'd2, 1'b0, 32'h0},
    '{4'd4, 3'd7, 2'd0, 16'h0000, 16'h0, 32'h0000_7FFE, 1'b1, 1'b1, 32'h0000_7FFE,  12'h00D, 3'd2, 1'b0, 32'h0},
    '{4'd4, 3'd3, 2'd2, 16'h0000, 16'h0, 32'h0000_3FFC, 1'b1, 1'b1, 32'h0000_3FFC,  12'h03D, 3'd3, 1'b0, 32'h0},
    '{4'd5, 3'd0, 2'd1, 16'hFFF0, 16'h0, 32'h0000_1FF0, 1'b1, 1'b0, 32'h0,          12'h00E, 3'd2, 1'b0, 32'h0},
    '{4'd7, 3'd0, 2'd1, 16'h0010, 16'h0, 32'h0000_1012, 1'b1, 1'b0, 32'h0,          12'h00E, 3'd2, 1'b0, 32'h0},
    '{4'd6, 3'd0, 2'd1, 16'h1004, 16'h0, 32'hFFFF_A006, 1'b1, 1'b0, 32'h0,          12'h039, 3'd3, 1'b0, 32'h0},
    '{4'd6, 3'd0, 2'd0, 16'h20FC, 16'h0, 32'h0000_20FC, 1'b1, 1'b0, 32'h0,          12'h039, 3'd3, 1'b0, 32'h0},
    '{4'd6, 3'd0, 2'd1, 16'h28FC, 16'h0, 32'h0001_20FC, 1'b1, 1'b0, 32'h0,          12'h039, 3'd3, 1'b0, 32'h0},
    '{4'd8, 3'd0, 2'd2, 16'h9010, 16'h0, 32'h0000_4012, 1'b1, 1'b0, 32'h0,          12'h0F9, 3'd4, 1'b0, 32'h0},
    '{4'd9, 3'd0, 2'd1, 16'h8000, 16'h0, 32'hFFFF_8000, 1'b1, 1'b0, 32'h0,          12'h00E, 3'd2, 1'b0, 32'h0},
    '{4'd9, 3'd0, 2'd0, 16'h1234, 16'h0, 32'h0000_1234, 1'b1, 1'b0, 32'h0,          12'h00E, 3'd2, 1'b0, 32'h0},
    '{4'd10,3'd0, 2'd2, 16'h0001, 16'h2340, 32'h0001_2340, 1'b1, 1'b0, 32'h0,       12'h0FA, 3'd4, 1'b0, 32'h0},
    '{4'd11,3'd0, 2'd1, 16'hBEEF, 16'h0, 32'h0,         1'b0, 1'b0, 32'h0,          12'h002, 3'd1, 1'b1, 32'h0000_BEEF},
    '{4'd11,3'd0, 2'd2, 16'hDEAD, 16'hBEEF, 32'h0,      1'b0, 1'b0, 32'h0,          12'h00A, 3'd2, 1'b1, 32'hDEAD_BEEF},
    '{4'd11,3'd0, 2'd0, 16'h12AB, 16'h0, 32'h0,         1'b0, 1'b0, 32'h0,          12'h002, 3'd1, 1'b1, 32'h0000_00AB},
    '{4'd0, 3'd1, 2'd2, 16'h0000, 16'h0, 32'h0,         1'b0, 1'b0, 32'h0,          12'h000, 3'd0, 1'b1, 32'hFFFF_8002},
    '{4'd1, 3'd2, 2'd1, 16'h0000, 16'h0, 32'h0,         1'b0, 1'b0, 32'h0,          12'h000, 3'd0, 1'b1, 32'hFFFF_FFFE},
    '{4'd3, 3'd2, 2'd2, 16'h0000, 16'h0, 32'hFFFF_FFFE, 1'b1, 1'b1, 32'h0000_0002,  12'h00F, 3'd2, 1'b0, 32'h0},
    '{4'd7, 3'd0, 2'd2, 16'h8000, 16'h0, 32'hFFFF_9002, 1'b1, 1'b0, 32'h0,          12'h03E, 3'd3, 1'b0, 32'h0}
  };

  function automatic logic [31:0] exp_operand(input vec_t v);
    if (v.fixed) return v.opv;
    case (v.size)
      2'd2:    return {mem(v.ea), mem(v.ea + 32'd2)};
      2'd1:    return {16'h0, mem(v.ea)};
      default: return {24'h0, mem(v.ea)[7:0]};
    endcase
  endfunction

  // Launch one operation; extra_start keeps start high that many busy cycles (R8).
  task automatic run_vec(input vec_t v, input int extra_start);
    logic [11:0] got_pat = '0;
    int k = 0;
    int rk = 0;
    @(negedge clk);
    mode = v.mode; reg_num = v.rnum; size = v.size; ext0 = v.ext0; ext1 = v.ext1;
    start = 1'b1;
    @(negedge clk);
    if (extra_start == 0) start = 1'b0;
    if (extra_start > 0) mode = 4'd0;
    while (!done && k < 8) begin
      if (k >= extra_start) start = 1'b0;
      check(busy == 1'b1, "R7 busy during operation", 32'(busy), 32'd1);
      got_pat = got_pat | (12'(cyc) << (2*k));
      if (cyc == 2'd3) begin
        check(bus_addr == v.ea + 32'(2*rk), "R5 R10 read address", bus_addr, v.ea + 32'(2*rk));
        rk++;
      end
      k++;
      @(negedge clk);
    end
    start = 1'b0;
    check(k == int'(v.plen), "R7 cycles to done", 32'(k), 32'(v.plen));
    check(got_pat == v.pat, "R4 microcycle order", 32'(got_pat), 32'(v.pat));
    if (v.chk_ea) check(ea == v.ea, "R1 R2 R10 effective address", ea, v.ea);
    check(operand == exp_operand(v), "R6 R5 operand", operand, exp_operand(v));
    check(wb_en == v.wb, "R3 write-back enable", 32'(wb_en), 32'(v.wb));
    if (v.wb) begin
      check(wb_val == v.wbv, "R3 write-back value", wb_val, v.wbv);
      check(wb_reg == v.rnum, "R3 write-back register", 32'(wb_reg), 32'(v.rnum));
    end
    @(negedge clk);
    check(!done && !busy, "R7 single done pulse", {30'h0, done, busy}, 32'h0);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i*32 +: 32] = reg_init(i);
    repeat (3) @(negedge clk);
    // R9: reset state
    check({cyc, busy, done, wb_en} == 5'b0, "R9 reset outputs", 32'({cyc, busy, done, wb_en}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cyc, busy, done, wb_en} == 5'b0, "R9 idle after reset", 32'({cyc, busy, done, wb_en}), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);

    // R8: start held high during an absolute-long fetch is ignored
    run_vec(VEC[16], 3);

    // R9: reset mid-operation abandons it
    @(negedge clk);
    mode = 4'd2; reg_num = 3'd0; size = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 operation started", 32'(busy), 32'd1);
    rst_n = 1'b0;
    #1;
    check({cyc, busy, done, wb_en} == 5'b0, "R9 mid-operation reset", 32'({cyc, busy, done, wb_en}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R9 stays idle after reset", {30'h0, busy, done}, 32'h0);

    // operation after reset still works
    run_vec(VEC[10], 0);
    finish_run();
  end
endmodule